// File: doc/BRIEF.md
# Configurable CRC Calculation Unit

This block keeps a running cyclic redundancy checksum over data words that a host writes through a plain strobe-and-data port. One shared engine serves four standard generator polynomials: an 8-bit, two 16-bit and a 32-bit one. The host loads a seed and picks bit reversal and ones-complement for the incoming data and for the reported result. Each of these four options can be set on its own. Every data write carries 8, 16 or 32 bits, and the checksum advances by exactly that many bits in the clock of the write.

In normal use the host selects the polynomial and the options, writes the seed and then streams words of any mix of widths. It reads the result on `crc_out` at any time. To finish a check it writes an expected value into a compare register and pulses a check strobe. A sticky mismatch flag records any difference until the host clears it.

Top module: `crc_unit`

## Requirements
- R1: `cfg_poly` selects the generator: 0 = 8-bit 0x07, 1 = 16-bit 0x1021, 2 = 16-bit 0x8005, 3 = 32-bit 0x04C11DB7. Bits are fed most significant first into a non-reflected shift register. For the ASCII bytes "123456789" the results are 0xF4 (code 0, seed 0), 0x29B1 (code 1, seed 0xFFFF), 0xBB3D (code 2, seed 0, input and output reversal) and 0xCBF43926 (code 3, seed 0xFFFFFFFF, input and output reversal, output complement).
- R2: A pulse on `seed_we` stores `seed_data` as the seed and loads it, masked to the polynomial width, into the checksum state. With no output options set, `crc_out` shows it in the next cycle.
- R3: A pulse on `restart` reloads the state from the stored seed. When `seed_we` or `restart` is high, a `data_we` in the same cycle is dropped. With no strobe high the state holds.
- R4: `data_size` gives the width of a write: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. The data sits in the low bits of `data_in`, and the bits above that width have no effect.
- R5: With `cfg_in_rev` set, the low n bits of a write are reversed before they are fed, so that data bit 0 enters first.
- R6: With `cfg_in_inv` set, the low n bits of a write are inverted before they are fed.
- R7: With `cfg_out_rev` set, `crc_out` shows the state with its polynomial-width bits reversed.
- R8: With `cfg_out_inv` set, `crc_out` shows the state with its polynomial-width bits inverted.
- R9: For the 8-bit and 16-bit polynomials, the bits of `crc_out` above the polynomial width are zero.
- R10: After a write in cycle t, `crc_out` shows the updated checksum from cycle t+1 on. Changing an output option changes `crc_out` combinationally.
- R11: `cmp_we` loads the compare register. A `cmp_check` pulse sets `mismatch` in the next cycle when `crc_out` differs from the compare value. The flag stays set until `mismatch_clr`, and the clear wins over a check in the same cycle.
- R12: After reset the seed, state and compare value are zero and `mismatch` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_poly | input | 2 | Polynomial select code |
| cfg_in_rev | input | 1 | Reverse bit order of written data |
| cfg_in_inv | input | 1 | Invert written data |
| cfg_out_rev | input | 1 | Reverse bit order of reported checksum |
| cfg_out_inv | input | 1 | Invert reported checksum |
| seed_we | input | 1 | Store seed and load state |
| seed_data | input | 32 | Seed value |
| restart | input | 1 | Reload state from stored seed |
| data_we | input | 1 | Data write strobe |
| data_size | input | 2 | Write width code |
| data_in | input | 32 | Write data, low aligned |
| cmp_we | input | 1 | Load compare register |
| cmp_data | input | 32 | Expected checksum |
| cmp_check | input | 1 | Compare result against expected value |
| mismatch_clr | input | 1 | Clear mismatch flag |
| crc_out | output | 32 | Current checksum after output options |
| mismatch | output | 1 | Sticky compare mismatch flag |

## Verification
A data write, seed load or restart driven before clock edge t is registered at t. Its effect on `crc_out` is due one edge later, so each task samples at the falling edge that follows the capturing edge. An output option change alters `crc_out` with no register in the path, but the bench still waits one falling edge before it samples. A check strobe sets `mismatch` one edge after the strobe is captured, and the bench samples the flag at the next falling edge and again after several idle cycles to confirm that it holds.

// File: rtl/crc_pkg.sv
package crc_pkg;
    localparam int WORD_W = 32;
    localparam int SIZE_W = 2;
    localparam int CNT_W  = $clog2(WORD_W) + 1;
    localparam int IDX_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        POLY_CRC8   = 2'd0,
        POLY_CCITT  = 2'd1,
        POLY_CRC16  = 2'd2,
        POLY_CRC32  = 2'd3
    } poly_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] seed;
        logic [WORD_W-1:0] state;
        logic [WORD_W-1:0] cmp;
        logic              mismatch;
    } crc_regs_t;

    function automatic logic [WORD_W-1:0] poly_taps(poly_sel_e sel);
        case (sel)
            POLY_CRC8:  return WORD_W'(32'h0000_0007);
            POLY_CCITT: return WORD_W'(32'h0000_1021);
            POLY_CRC16: return WORD_W'(32'h0000_8005);
            default:    return WORD_W'(32'h04C1_1DB7);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] poly_width(poly_sel_e sel);
        case (sel)
            POLY_CRC8:  return CNT_W'(8);
            POLY_CCITT: return CNT_W'(16);
            POLY_CRC16: return CNT_W'(16);
            default:    return CNT_W'(32);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] size_bits(logic [SIZE_W-1:0] code);
        case (code)
            2'd0:    return CNT_W'(8);
            2'd1:    return CNT_W'(16);
            default: return CNT_W'(32);
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] width_mask(logic [CNT_W-1:0] w);
        if (int'(w) >= WORD_W) return '1;
        return (WORD_W'(1) << w) - WORD_W'(1);
    endfunction
endpackage

// File: rtl/crc_xform.sv
module crc_xform
    import crc_pkg::*;
(
    input  logic [WORD_W-1:0] din,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              rev,
    input  logic              inv,
    output logic [WORD_W-1:0] dout
);
    logic [WORD_W-1:0] field;

    always_comb begin
        field = din & width_mask(nbits);
        if (inv) field = field ^ width_mask(nbits);
        dout = field;
        if (rev) begin
            dout = '0;
            for (int i = 0; i < WORD_W; i++) begin
                if (i < int'(nbits)) dout[int'(nbits) - 1 - i] = field[i];
            end
        end
    end
endmodule

// File: rtl/crc_advance.sv
module crc_advance
    import crc_pkg::*;
(
    input  logic [WORD_W-1:0] state_in,
    input  logic [WORD_W-1:0] feed,
    input  logic [CNT_W-1:0]  nbits,
    input  logic [WORD_W-1:0] taps,
    input  logic [CNT_W-1:0]  width,
    output logic [WORD_W-1:0] state_out
);
    logic [WORD_W-1:0] msk;
    logic [IDX_W-1:0]  top;
    logic [WORD_W-1:0] s;
    logic              fb;

    always_comb begin
        msk = width_mask(width);
        top = IDX_W'(width - CNT_W'(1));
        s   = state_in & msk;
        fb  = 1'b0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (i < int'(nbits)) begin
                fb = s[top] ^ feed[i];
                s  = (s << 1) & msk;
                if (fb) s = s ^ taps;
            end
        end
        state_out = s;
    end
endmodule

// File: rtl/crc_unit.sv
module crc_unit
    import crc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_poly,
    input  logic                 cfg_in_rev,
    input  logic                 cfg_in_inv,
    input  logic                 cfg_out_rev,
    input  logic                 cfg_out_inv,
    input  logic                 seed_we,
    input  logic [WORD_W-1:0]    seed_data,
    input  logic                 restart,
    input  logic                 data_we,
    input  logic [SIZE_W-1:0]    data_size,
    input  logic [WORD_W-1:0]    data_in,
    input  logic                 cmp_we,
    input  logic [WORD_W-1:0]    cmp_data,
    input  logic                 cmp_check,
    input  logic                 mismatch_clr,
    output logic [WORD_W-1:0]    crc_out,
    output logic                 mismatch
);
    poly_sel_e          poly;
    logic [CNT_W-1:0]   pwidth;
    logic [CNT_W-1:0]   wbits;
    logic [WORD_W-1:0]  pmask;
    logic [WORD_W-1:0]  feed;
    logic [WORD_W-1:0]  advanced;
    crc_regs_t          regs_d, regs_q;

    always_comb begin
        poly   = poly_sel_e'(cfg_poly);
        pwidth = poly_width(poly);
        pmask  = width_mask(pwidth);
        wbits  = size_bits(data_size);
    end

    crc_xform u_in_xf (
        .din   (data_in),
        .nbits (wbits),
        .rev   (cfg_in_rev),
        .inv   (cfg_in_inv),
        .dout  (feed)
    );

    crc_advance u_adv (
        .state_in  (regs_q.state),
        .feed      (feed),
        .nbits     (wbits),
        .taps      (poly_taps(poly)),
        .width     (pwidth),
        .state_out (advanced)
    );

    crc_xform u_out_xf (
        .din   (regs_q.state),
        .nbits (pwidth),
        .rev   (cfg_out_rev),
        .inv   (cfg_out_inv),
        .dout  (crc_out)
    );

    always_comb begin
        regs_d = regs_q;
        if (seed_we) begin
            regs_d.seed  = seed_data;
            regs_d.state = seed_data & pmask;
        end else if (restart) begin
            regs_d.state = regs_q.seed & pmask;
        end else if (data_we) begin
            regs_d.state = advanced;
        end
        if (cmp_we) regs_d.cmp = cmp_data;
        if (mismatch_clr) begin
            regs_d.mismatch = 1'b0;
        end else if (cmp_check && (crc_out != regs_q.cmp)) begin
            regs_d.mismatch = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign mismatch = regs_q.mismatch;
endmodule

// File: rtl/crc_unit_chk.sv
module crc_unit_chk
    import crc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_poly,
    input logic              seed_we,
    input logic [WORD_W-1:0] seed_data,
    input logic              restart,
    input logic              data_we,
    input logic              mismatch_clr,
    input logic [WORD_W-1:0] crc_out,
    input logic              mismatch,
    input crc_regs_t         regs
);
    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_out & ~width_mask(poly_width(poly_sel_e'(cfg_poly)))) == '0);

    // R2
    seed_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_we |=> regs.seed == $past(seed_data));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_we && !restart && !data_we) |=> $stable(regs.state));

    // R3
    restart_keeps_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !seed_we) |=> $stable(regs.seed));

    // R11
    mismatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !mismatch_clr) |=> mismatch);

    // R11
    mismatch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_clr |=> !mismatch);
endmodule

bind crc_unit crc_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_poly     (cfg_poly),
    .seed_we      (seed_we),
    .seed_data    (seed_data),
    .restart      (restart),
    .data_we      (data_we),
    .mismatch_clr (mismatch_clr),
    .crc_out      (crc_out),
    .mismatch     (mismatch),
    .regs         (regs_q)
);

// File: tb/crc_unit_bench.sv
module crc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_poly = '0;
    logic        cfg_in_rev = 1'b0, cfg_in_inv = 1'b0;
    logic        cfg_out_rev = 1'b0, cfg_out_inv = 1'b0;
    logic        seed_we = 1'b0, restart = 1'b0, data_we = 1'b0;
    logic [31:0] seed_data = '0, data_in = '0, cmp_data = '0;
    logic [1:0]  data_size = '0;
    logic        cmp_we = 1'b0, cmp_check = 1'b0, mismatch_clr = 1'b0;
    logic [31:0] crc_out;
    logic        mismatch;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    crc_unit u_crc_unit (
        .clk(clk), .rst_n(rst_n), .cfg_poly(cfg_poly),
        .cfg_in_rev(cfg_in_rev), .cfg_in_inv(cfg_in_inv),
        .cfg_out_rev(cfg_out_rev), .cfg_out_inv(cfg_out_inv),
        .seed_we(seed_we), .seed_data(seed_data), .restart(restart),
        .data_we(data_we), .data_size(data_size), .data_in(data_in),
        .cmp_we(cmp_we), .cmp_data(cmp_data), .cmp_check(cmp_check),
        .mismatch_clr(mismatch_clr), .crc_out(crc_out), .mismatch(mismatch)
    );

    task automatic expect_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] p, input logic ir, input logic ii, input logic orv, input logic oi);
        @(negedge clk);
        cfg_poly = p; cfg_in_rev = ir; cfg_in_inv = ii; cfg_out_rev = orv; cfg_out_inv = oi;
    endtask

    task automatic load_seed(input logic [31:0] s);
        @(negedge clk); seed_data = s; seed_we = 1'b1;
        @(negedge clk); seed_we = 1'b0;
    endtask

    task automatic put(input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk); data_in = d; data_size = sz; data_we = 1'b1;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic put_digits(input logic invert);
        for (int k = 0; k < 9; k++) begin
            logic [7:0] b;
            b = 8'h31 + 8'(k);
            if (invert) b = ~b;
            put({24'hA5C3E7, b}, 2'd0);
        end
    endtask

    task automatic t_reset;
        expect_val("R12 reset crc_out", crc_out, 32'h0);
        expect_val("R12 reset mismatch", {31'h0, mismatch}, 32'h0);
    endtask

    task automatic t_standard_vectors;
        cfg(2'd0, 0, 0, 0, 0); load_seed(32'h0); put_digits(1'b0);
        expect_val("R1 crc8 vector", crc_out, 32'h0000_00F4);
        cfg(2'd1, 0, 0, 0, 0); load_seed(32'hFFFF); put_digits(1'b0);
        expect_val("R1 ccitt vector", crc_out, 32'h0000_29B1);
        cfg(2'd2, 1, 0, 1, 0); load_seed(32'h0); put_digits(1'b0);
        expect_val("R1 R5 crc16 reflected vector", crc_out, 32'h0000_BB3D);
        cfg(2'd3, 1, 0, 1, 1); load_seed(32'hFFFF_FFFF); put_digits(1'b0);
        expect_val("R1 R5 R8 crc32 vector", crc_out, 32'hCBF4_3926);
    endtask

    task automatic t_mixed_widths;
        // R4: mixed write widths with junk above the used bits
        cfg(2'd1, 0, 0, 0, 0); load_seed(32'hFFFF);
        put(32'h3132_3334, 2'd3);
        put(32'hDEAD_3536, 2'd1);
        put(32'h1234_5637, 2'd0);
        put(32'hBEEF_3839, 2'd1);
        expect_val("R4 ccitt mixed widths", crc_out, 32'h0000_29B1);
        expect_val("R9 upper bits zero", crc_out & 32'hFFFF_0000, 32'h0);
        // R5: 16-bit reflected writes feed the low byte first
        cfg(2'd2, 1, 0, 1, 0); load_seed(32'h0);
        put(32'h0000_3231, 2'd1); put(32'hFFFF_3433, 2'd1);
        put(32'h0000_3635, 2'd1); put(32'h0000_3837, 2'd1);
        put(32'h0000_0039, 2'd0);
        expect_val("R5 reflected 16-bit writes", crc_out, 32'h0000_BB3D);
        // R6
        cfg(2'd0, 0, 1, 0, 0); load_seed(32'h0); put_digits(1'b1);
        expect_val("R6 inverted input", crc_out, 32'h0000_00F4);
    endtask

    task automatic t_output_opts;
        cfg(2'd1, 0, 0, 0, 0); load_seed(32'hFFFF); put_digits(1'b0);
        cfg(2'd1, 0, 0, 0, 1); @(negedge clk);
        expect_val("R8 output complement", crc_out, 32'h0000_D64E);
        cfg(2'd1, 0, 0, 1, 0); @(negedge clk);
        expect_val("R7 output reversal", crc_out, 32'h0000_8D94);
        cfg(2'd1, 0, 0, 0, 0); @(negedge clk);
        expect_val("R10 state unchanged by output options", crc_out, 32'h0000_29B1);
    endtask

    task automatic t_seed_restart;
        cfg(2'd1, 0, 0, 0, 0); load_seed(32'h1234_5678);
        expect_val("R2 seed visible masked", crc_out, 32'h0000_5678);
        put(32'h0000_00AA, 2'd0);
        checks++;
        if (crc_out == 32'h0000_5678) begin
            failures++;
            $display("FAIL R10 write not applied actual=%08h expected!=%08h", crc_out, 32'h5678);
        end
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        expect_val("R3 restart reloads seed", crc_out, 32'h0000_5678);
        @(negedge clk); restart = 1'b1; data_we = 1'b1; data_in = 32'h55; data_size = 2'd0;
        @(negedge clk); restart = 1'b0; data_we = 1'b0;
        expect_val("R3 data dropped under restart", crc_out, 32'h0000_5678);
        repeat (3) @(negedge clk);
        expect_val("R3 idle hold", crc_out, 32'h0000_5678);
    endtask

    task automatic pulse_check;
        @(negedge clk); cmp_check = 1'b1;
        @(negedge clk); cmp_check = 1'b0;
    endtask

    task automatic t_compare;
        cfg(2'd1, 0, 0, 0, 0); load_seed(32'hFFFF); put_digits(1'b0);
        @(negedge clk); cmp_we = 1'b1; cmp_data = 32'h0000_29B1;
        @(negedge clk); cmp_we = 1'b0;
        pulse_check();
        expect_val("R11 equal no mismatch", {31'h0, mismatch}, 32'h0);
        @(negedge clk); cmp_we = 1'b1; cmp_data = 32'h0000_1234;
        @(negedge clk); cmp_we = 1'b0;
        pulse_check();
        expect_val("R11 mismatch set", {31'h0, mismatch}, 32'h1);
        repeat (4) @(negedge clk);
        expect_val("R11 mismatch sticky", {31'h0, mismatch}, 32'h1);
        @(negedge clk); mismatch_clr = 1'b1; cmp_check = 1'b1;
        @(negedge clk); mismatch_clr = 1'b0; cmp_check = 1'b0;
        expect_val("R11 clear wins", {31'h0, mismatch}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_standard_vectors();
        t_mixed_widths();
        t_output_opts();
        t_seed_restart();
        t_compare();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule